// File: doc/BRIEF.md
# Self-Timed Video Sink with Stream Resynchronisation

This block is the last stage of a streamed video pipeline, where the display side owns the pixel timing. A pair of free-running counters walks every line and frame of a configured mode. The counters produce data-enable, horizontal sync and vertical sync. The block pulls pixels from an AXI4-Stream input, with TREADY high only while the raster is in its visible area. Each accepted pixel appears on a registered pixel output. During blanking, and whenever the stream is not trusted, the pixel output is black, so the display timing never stops.

Each accepted beat carries markers, and the block compares them with its own raster position. Two marker conventions are selectable. On a mismatch the block stops trusting the stream. It drains the input up to the frame boundary, waits for its own next frame start, and then locks again. A sticky underrun flag records every cycle in which the sink asked for a pixel and none was offered. A saturating glitch counter counts the recoveries. A steady count means the pipeline is aligned.

Mode settings are register inputs. They are sampled once after reset and again at every frame wrap, so a change made mid-frame shows up only in the next frame.

Top module: `pixel_sink_resync`

## Requirements
- R1: One line lasts hact+hfp+hsw+hbp cycles and starts with hact active cycles. A frame holds vact active lines followed by vfp+vsw+vbp blank lines. `pix_hsync` is high for hsw cycles, starting hfp cycles after the active part of the line ends. `pix_vsync` is high for vsw whole lines, starting after vfp blank lines. All pixel outputs are registered, one cycle after the raster position they describe.
- R2: While locked, `s_tready` is high only in visible cycles. A pixel accepted in cycle t drives `pix_data` in cycle t+1, with `pix_de` high. Pixels keep their order.
- R3: `pix_data` is zero in every cycle where `pix_de` is low. It is also zero for a visible cycle whose pixel was not accepted while locked.
- R4: With `cfg_sof_mode`=1, TUSER is expected only at position (0,0) and TLAST only at column hact-1. With `cfg_sof_mode`=0, TLAST is expected only at column hact-1 of line vact-1, and TUSER only at column hact-1. A stream that follows the selected convention never triggers a recovery.
- R5: A locked beat whose markers disagree with the raster position starts a recovery, and TREADY then stays high. With `cfg_sof_mode`=0, draining ends when a beat with TLAST is accepted. If the offending beat itself carries TLAST, there is no draining at all. With `cfg_sof_mode`=1, draining ends when a beat with TUSER is offered, and that beat is left unaccepted.
- R6: After draining, TREADY stays low until the raster reaches (0,0). From that cycle the block is locked again, and later frames show the stream pixel-exact.
- R7: `err_underrun` becomes 1 after any cycle with TREADY high and TVALID low, and it stays 1.
- R8: `glitch_count` rises by one on every recovery and saturates at its maximum.
- R9: A one-cycle `stat_clr` pulse returns `err_underrun` and `glitch_count` to zero in the next cycle. A new event in the same cycle still registers.
- R10: The mode inputs, including `cfg_sof_mode`, take effect only from the first pixel of the next frame.
- R11: While reset is asserted, `s_tready`, `pix_de`, `pix_hsync`, `pix_vsync`, `pix_data`, `err_underrun` and `glitch_count` are all zero. After release, the raster starts at (0,0) in the locked state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_tvalid | input | 1 | Stream pixel valid |
| s_tready | output | 1 | Stream pixel accept |
| s_tdata | input | PW | Stream pixel value |
| s_tuser | input | 1 | Stream marker (start of frame or end of line, by mode) |
| s_tlast | input | 1 | Stream marker (end of line or end of frame, by mode) |
| cfg_hact | input | CW | Visible pixels per line |
| cfg_hfp | input | CW | Horizontal front porch cycles |
| cfg_hsw | input | CW | Horizontal sync cycles |
| cfg_hbp | input | CW | Horizontal back porch cycles |
| cfg_vact | input | CW | Visible lines per frame |
| cfg_vfp | input | CW | Vertical front porch lines |
| cfg_vsw | input | CW | Vertical sync lines |
| cfg_vbp | input | CW | Vertical back porch lines |
| cfg_sof_mode | input | 1 | 1: TUSER start of frame, TLAST end of line; 0: TLAST end of frame, TUSER end of line |
| stat_clr | input | 1 | Pulse clearing the error flag and glitch counter |
| pix_data | output | PW | Displayed pixel, zero when blank or not locked |
| pix_de | output | 1 | Visible-area enable |
| pix_hsync | output | 1 | Horizontal sync, active high |
| pix_vsync | output | 1 | Vertical sync, active high |
| err_underrun | output | 1 | Sticky flag: a pixel was requested and none was offered |
| glitch_count | output | GW | Saturating count of resynchronisations |

## Verification
A raster counter that runs one step off shows up on the next line as a wrong `pix_de` run length or a wrong sync offset. A slip in the lock state shows up differently. It either stalls the stream, so pixels arrive late and `pix_data` no longer matches its position in the frame, or it leaves the glitch count at an unexpected value once the stream is clean again. The bench injects a skipped pixel, a stalled pixel and a truncated frame in each marker convention. It requires exactly one recovery in each case, and pixel-exact frames within two frames after the fault.

// File: rtl/vsink_pkg.sv
package vsink_pkg;

  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_FLUSH  = 2'd1,
    LK_WAIT   = 2'd2
  } lock_st_e;

  // True when the markers of a beat agree with the raster position it lands on.
  function automatic logic marks_agree(input logic sof_mode, input logic tuser,
                                       input logic tlast, input logic first_px,
                                       input logic eol, input logic last_line);
    if (sof_mode) return (tuser == first_px) && (tlast == eol);
    else          return (tlast == (eol && last_line)) && (tuser == eol);
  endfunction

endpackage

// File: rtl/vsink_timing.sv
module vsink_timing #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_hact,
  input  logic [CW-1:0] cfg_hfp,
  input  logic [CW-1:0] cfg_hsw,
  input  logic [CW-1:0] cfg_hbp,
  input  logic [CW-1:0] cfg_vact,
  input  logic [CW-1:0] cfg_vfp,
  input  logic [CW-1:0] cfg_vsw,
  input  logic [CW-1:0] cfg_vbp,
  input  logic          cfg_sof_mode,
  output logic          act,
  output logic          hs,
  output logic          vs,
  output logic          at_first,
  output logic          at_eol,
  output logic          at_lastline,
  output logic          frame_end,
  output logic          mode_sof
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] hact_q, hfp_q, hsw_q, hbp_q, vact_q, vfp_q, vsw_q, vbp_q;
  logic          sof_q, run_q;
  logic [CW-1:0] hcnt_q, vcnt_q, hcnt_d, vcnt_d;
  logic [CW-1:0] htot, vtot, hs_beg, vs_beg;
  logic          line_end, last_line_cnt, load_en;

  always_comb begin
    htot          = hact_q + hfp_q + hsw_q + hbp_q;
    vtot          = vact_q + vfp_q + vsw_q + vbp_q;
    hs_beg        = hact_q + hfp_q;
    vs_beg        = vact_q + vfp_q;
    line_end      = (hcnt_q == htot - ONE);
    last_line_cnt = (vcnt_q == vtot - ONE);
    frame_end     = run_q && line_end && last_line_cnt;
    // mode registers load on the first running cycle and at every frame wrap
    load_en       = !run_q || frame_end;
    hcnt_d        = hcnt_q;
    vcnt_d        = vcnt_q;
    if (run_q) begin
      if (line_end) begin
        hcnt_d = '0;
        vcnt_d = last_line_cnt ? '0 : vcnt_q + ONE;
      end else begin
        hcnt_d = hcnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hact_q <= '0; hfp_q <= '0; hsw_q <= '0; hbp_q <= '0;
      vact_q <= '0; vfp_q <= '0; vsw_q <= '0; vbp_q <= '0;
      sof_q  <= 1'b0;
      run_q  <= 1'b0;
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else begin
      if (load_en) begin
        hact_q <= cfg_hact; hfp_q <= cfg_hfp; hsw_q <= cfg_hsw; hbp_q <= cfg_hbp;
        vact_q <= cfg_vact; vfp_q <= cfg_vfp; vsw_q <= cfg_vsw; vbp_q <= cfg_vbp;
        sof_q  <= cfg_sof_mode;
      end
      run_q  <= 1'b1;
      hcnt_q <= hcnt_d;
      vcnt_q <= vcnt_d;
    end
  end

  always_comb begin
    act         = run_q && (hcnt_q < hact_q) && (vcnt_q < vact_q);
    hs          = run_q && (hcnt_q >= hs_beg) && (hcnt_q < hs_beg + hsw_q);
    vs          = run_q && (vcnt_q >= vs_beg) && (vcnt_q < vs_beg + vsw_q);
    at_first    = (hcnt_q == '0) && (vcnt_q == '0);
    at_eol      = (hcnt_q == hact_q - ONE);
    at_lastline = (vcnt_q == vact_q - ONE);
    mode_sof    = sof_q;
  end

  // R1
  raster_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> ((hcnt_q < htot) && (vcnt_q < vtot)));

  // R10
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> ((hcnt_q == '0) && (vcnt_q == '0)));

endmodule

// File: rtl/vsink_lock.sv
module vsink_lock
  import vsink_pkg::*;
#(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tvalid,
  input  logic          tuser,
  input  logic          tlast,
  output logic          tready,
  input  logic          act,
  input  logic          at_first,
  input  logic          at_eol,
  input  logic          at_lastline,
  input  logic          frame_end,
  input  logic          mode_sof,
  input  logic          clr,
  output logic          take,
  output logic          err_underrun,
  output logic [GW-1:0] glitch_count
);
  localparam logic [GW-1:0] GMAX = '1;
  localparam logic [GW-1:0] GONE = GW'(1);

  lock_st_e      st_q, st_d;
  logic          beat, pos_ok, resync, end_mark;
  logic          err_q, err_d;
  logic [GW-1:0] glitch_q, glitch_d;

  always_comb begin
    unique case (st_q)
      LK_LOCKED: tready = act;
      // SOF convention: hold back the start beat of the next frame
      LK_FLUSH:  tready = mode_sof ? !(tvalid && tuser) : 1'b1;
      default:   tready = 1'b0;
    endcase
    beat     = tvalid && tready;
    end_mark = mode_sof ? tuser : tlast;
    pos_ok   = marks_agree(mode_sof, tuser, tlast, at_first, at_eol, at_lastline);
    resync   = (st_q == LK_LOCKED) && beat && !pos_ok;
    take     = (st_q == LK_LOCKED) && beat && pos_ok;

    st_d = st_q;
    unique case (st_q)
      LK_LOCKED: if (resync) st_d = (!mode_sof && tlast) ? LK_WAIT : LK_FLUSH;
      LK_FLUSH:  if (tvalid && end_mark) st_d = LK_WAIT;
      default:   if (frame_end) st_d = LK_LOCKED;
    endcase

    // a new event in the clearing cycle still counts
    err_d    = (err_q && !clr) || (tready && !tvalid);
    glitch_d = clr ? '0 : glitch_q;
    if (resync && (glitch_d != GMAX)) glitch_d = glitch_d + GONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= LK_LOCKED;
      err_q    <= 1'b0;
      glitch_q <= '0;
    end else begin
      st_q     <= st_d;
      err_q    <= err_d;
      glitch_q <= glitch_d;
    end
  end

  assign err_underrun = err_q;
  assign glitch_count = glitch_q;

  // R2
  ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tready |-> (act || (st_q == LK_FLUSH)));

  // R7
  underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tready && !tvalid) |=> err_underrun);

  // R6
  relock_at_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st_q) == LK_WAIT) && (st_q == LK_LOCKED)) |-> at_first);

  // R8
  glitch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glitch_q > $past(glitch_q)) |-> (($past(st_q) == LK_LOCKED) && (st_q != LK_LOCKED)));

endmodule

// File: rtl/vsink_out.sv
module vsink_out #(
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic          hs,
  input  logic          vs,
  input  logic          take,
  input  logic [PW-1:0] tdata,
  output logic [PW-1:0] pix_data,
  output logic          pix_de,
  output logic          pix_hsync,
  output logic          pix_vsync
);
  logic [PW-1:0] pix_d;

  always_comb pix_d = take ? tdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_data  <= '0;
      pix_de    <= 1'b0;
      pix_hsync <= 1'b0;
      pix_vsync <= 1'b0;
    end else begin
      pix_data  <= pix_d;
      pix_de    <= act;
      pix_hsync <= hs;
      pix_vsync <= vs;
    end
  end

  // R3
  black_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_de |-> (pix_data == '0));

endmodule

// File: rtl/pixel_sink_resync.sv
module pixel_sink_resync #(
  parameter int PW = 24,
  parameter int CW = 12,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          s_tvalid,
  output logic          s_tready,
  input  logic [PW-1:0] s_tdata,
  input  logic          s_tuser,
  input  logic          s_tlast,
  input  logic [CW-1:0] cfg_hact,
  input  logic [CW-1:0] cfg_hfp,
  input  logic [CW-1:0] cfg_hsw,
  input  logic [CW-1:0] cfg_hbp,
  input  logic [CW-1:0] cfg_vact,
  input  logic [CW-1:0] cfg_vfp,
  input  logic [CW-1:0] cfg_vsw,
  input  logic [CW-1:0] cfg_vbp,
  input  logic          cfg_sof_mode,
  input  logic          stat_clr,
  output logic [PW-1:0] pix_data,
  output logic          pix_de,
  output logic          pix_hsync,
  output logic          pix_vsync,
  output logic          err_underrun,
  output logic [GW-1:0] glitch_count
);
  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       act, hs, vs, at_first, at_eol, at_lastline, frame_end, mode_sof, take;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  vsink_timing #(.CW(CW)) timing_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_hact(cfg_hact), .cfg_hfp(cfg_hfp), .cfg_hsw(cfg_hsw), .cfg_hbp(cfg_hbp),
    .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp), .cfg_vsw(cfg_vsw), .cfg_vbp(cfg_vbp),
    .cfg_sof_mode(cfg_sof_mode),
    .act(act), .hs(hs), .vs(vs), .at_first(at_first), .at_eol(at_eol),
    .at_lastline(at_lastline), .frame_end(frame_end), .mode_sof(mode_sof)
  );

  vsink_lock #(.GW(GW)) lock_i (
    .clk(clk), .rst_n(rst_n),
    .tvalid(s_tvalid), .tuser(s_tuser), .tlast(s_tlast), .tready(s_tready),
    .act(act), .at_first(at_first), .at_eol(at_eol), .at_lastline(at_lastline),
    .frame_end(frame_end), .mode_sof(mode_sof), .clr(stat_clr),
    .take(take), .err_underrun(err_underrun), .glitch_count(glitch_count)
  );

  vsink_out #(.PW(PW)) out_i (
    .clk(clk), .rst_n(rst_n),
    .act(act), .hs(hs), .vs(vs), .take(take), .tdata(s_tdata),
    .pix_data(pix_data), .pix_de(pix_de), .pix_hsync(pix_hsync), .pix_vsync(pix_vsync)
  );

  // R2
  taken_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> pix_de);

endmodule

// File: tb/pixel_sink_resync_tb_top.sv
module pixel_sink_resync_tb_top;
  localparam int PW = 24;
  localparam int CW = 12;
  localparam int GW = 8;
  localparam int W = 4, H = 3, HFP = 1, HSW = 2, HBP = 1, VFP = 1, VSW = 2, VBP = 1;
  localparam int HTOT = W + HFP + HSW + HBP;
  localparam int LIMIT = 150000;

  typedef struct packed {
    logic       sof;
    logic [1:0] fault;   // 0 none, 1 skip, 2 stall, 3 truncate
    logic [3:0] exp_g;
    logic       exp_u;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b1, 2'd0, 4'd0, 1'b0},
    '{1'b0, 2'd0, 4'd0, 1'b0},
    '{1'b1, 2'd1, 4'd1, 1'b0},
    '{1'b0, 2'd1, 4'd1, 1'b0},
    '{1'b1, 2'd3, 4'd1, 1'b0},
    '{1'b0, 2'd3, 4'd1, 1'b0},
    '{1'b1, 2'd2, 4'd1, 1'b1},
    '{1'b0, 2'd2, 4'd1, 1'b1}
  };

  logic          clk = 1'b0;
  logic          arst_n = 1'b0;
  logic          s_tvalid = 1'b0, s_tuser = 1'b0, s_tlast = 1'b0, stat_clr = 1'b0;
  logic [PW-1:0] s_tdata = '0;
  logic          s_tready;
  logic [CW-1:0] cfg_hact = CW'(W);
  logic          cfg_sof_mode = 1'b1;
  logic [PW-1:0] pix_data;
  logic          pix_de, pix_hsync, pix_vsync, err_underrun;
  logic [GW-1:0] glitch_count;

  always #10 clk = ~clk;

  pixel_sink_resync #(.PW(PW), .CW(CW), .GW(GW)) dut_i (
    .clk(clk), .arst_n(arst_n),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .s_tuser(s_tuser), .s_tlast(s_tlast),
    .cfg_hact(cfg_hact), .cfg_hfp(CW'(HFP)), .cfg_hsw(CW'(HSW)), .cfg_hbp(CW'(HBP)),
    .cfg_vact(CW'(H)), .cfg_vfp(CW'(VFP)), .cfg_vsw(CW'(VSW)), .cfg_vbp(CW'(VBP)),
    .cfg_sof_mode(cfg_sof_mode), .stat_clr(stat_clr),
    .pix_data(pix_data), .pix_de(pix_de), .pix_hsync(pix_hsync), .pix_vsync(pix_vsync),
    .err_underrun(err_underrun), .glitch_count(glitch_count)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  // source model state
  int sx, sy, sframe;
  bit fault_done;
  int cur_fault;
  // monitor state
  int frames, ox, oy, bad, trdy_bad, de_cnt, last_de;
  int hs_run, hs_len, vs_run, vs_len, gap_run, gap_len, de_run, de_run_last, de_falls;
  int since_rise, rise_period;
  bit prev_tready, prev_de, prev_hs, prev_vs, saw_de;

  function automatic logic [PW-1:0] enc(input int x, input int y);
    return {8'hA5, 8'(y), 8'(x)};
  endfunction

  task automatic chk(input string req, input longint act_v, input longint exp_v);
    checks++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  always @(posedge clk) cyc++;

  task automatic monitor();
    if (pix_vsync && !prev_vs) begin
      frames++; ox = 0; oy = 0; last_de = de_cnt; de_cnt = 0;
    end
    if (frames >= 3) begin
      if (pix_de) begin
        if (pix_data != enc(ox, oy)) bad++;
        ox++;
        if (ox == W) begin ox = 0; oy++; end
      end else if (pix_data != '0) bad++;
      if (prev_tready && !pix_de) trdy_bad++;
    end
    if (pix_de) de_cnt++;
    // run lengths
    if (pix_hsync) hs_run++; else if (prev_hs) begin hs_len = hs_run; hs_run = 0; end
    if (pix_vsync) vs_run++; else if (prev_vs) begin vs_len = vs_run; vs_run = 0; end
    if (pix_de) begin gap_run = 0; saw_de = 1'b1; end
    else if (!pix_hsync) gap_run++;
    if (pix_hsync && !prev_hs) begin
      if (saw_de) gap_len = gap_run;
      saw_de = 1'b0;
    end
    if (pix_de) de_run++; else if (prev_de) begin de_run_last = de_run; de_run = 0; de_falls++; end
    since_rise++;
    if (pix_de && !prev_de) begin rise_period = since_rise; since_rise = 0; end
    prev_de = pix_de; prev_hs = pix_hsync; prev_vs = pix_vsync;
  endtask

  task automatic step();
    bit trunc, acc;
    @(negedge clk);
    monitor();
    if (cur_fault == 1 && !fault_done && sframe == 1 && sx == 1 && sy == 1) begin
      sx = 2; fault_done = 1'b1;
    end
    s_tvalid = 1'b1;
    if (cur_fault == 2 && !fault_done && sframe == 1 && sx == 2 && sy == 1) begin
      s_tvalid = 1'b0; fault_done = 1'b1;
    end
    trunc = (cur_fault == 3) && !fault_done && sframe == 1 && sx == 1 && sy == 1;
    s_tdata = enc(sx, sy);
    if (cfg_sof_mode) begin
      s_tuser = (sx == 0 && sy == 0);
      s_tlast = (sx == W - 1);
    end else begin
      s_tuser = (sx == W - 1);
      s_tlast = (sx == W - 1 && sy == H - 1);
    end
    if (trunc) s_tlast = 1'b1;
    #2;
    acc = s_tvalid && s_tready;
    prev_tready = s_tready;
    if (acc) begin
      if (trunc) begin
        fault_done = 1'b1; sx = 0; sy = 0; sframe++;
      end else begin
        sx++;
        if (sx == W) begin
          sx = 0; sy++;
          if (sy == H) begin sy = 0; sframe++; end
        end
      end
    end
  endtask

  task automatic do_reset(input bit sofm, input int fault, input bit check_idle);
    @(negedge clk);
    arst_n = 1'b0; s_tvalid = 1'b0; stat_clr = 1'b0;
    cfg_sof_mode = sofm; cfg_hact = CW'(W); cur_fault = fault;
    sx = 0; sy = 0; sframe = 0; fault_done = 1'b0;
    frames = 0; ox = 0; oy = 0; bad = 0; trdy_bad = 0; de_cnt = 0; last_de = 0;
    hs_run = 0; vs_run = 0; gap_run = 0; de_run = 0; de_falls = 0; since_rise = 0;
    prev_tready = 0; prev_de = 0; prev_hs = 0; prev_vs = 0; saw_de = 0;
    repeat (3) @(negedge clk);
    if (check_idle) begin
      // R11 reset state at the ports
      chk("R11 tready in reset", s_tready, 0);
      chk("R11 de/sync in reset", {pix_de, pix_hsync, pix_vsync}, 0);
      chk("R11 pixel in reset", pix_data, 0);
      chk("R11 underrun in reset", err_underrun, 0);
      chk("R11 glitch in reset", glitch_count, 0);
    end
    arst_n = 1'b1;
  endtask

  task automatic run_frames(input int n);
    while (frames < n) step();
  endtask

  initial begin
    for (int r = 0; r < 8; r++) begin
      do_reset(VECS[r].sof, int'(VECS[r].fault), r == 0);
      run_frames(5);
      chk($sformatf("R4 R5 R8 glitches row %0d", r), glitch_count, VECS[r].exp_g);
      chk($sformatf("R7 underrun row %0d", r), err_underrun, VECS[r].exp_u);
      chk($sformatf("R2 R3 R6 pixel mismatches row %0d", r), bad, 0);
      chk($sformatf("R2 ready outside active row %0d", r), trdy_bad, 0);
      chk($sformatf("R1 active pixels per frame row %0d", r), last_de, W * H);
      if (r == 0) begin
        chk("R1 hsync width", hs_len, HSW);
        chk("R1 vsync width", vs_len, VSW * HTOT);
        chk("R1 front porch", gap_len, HFP);
        chk("R1 line period", rise_period, HTOT);
      end
    end

    // R9: clear after the stall row left both statuses set
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
    chk("R9 glitch cleared", glitch_count, 0);
    chk("R9 underrun cleared", err_underrun, 0);

    // R10: width change mid-frame applies from the next frame
    do_reset(1'b1, 0, 1'b0);
    run_frames(1);
    while (!pix_de) step();
    cfg_hact = CW'(W + 1);
    begin
      int f0;
      f0 = de_falls;
      while (de_falls == f0) step();
      chk("R10 current line keeps width", de_run_last, W);
      while (de_falls == f0 + 1) step();
      chk("R10 later line same frame keeps width", de_run_last, W);
      run_frames(2);
      f0 = de_falls;
      while (de_falls == f0) step();
      chk("R10 next frame uses new width", de_run_last, W + 1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= LIMIT);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule